// File: doc/BRIEF.md
# Interrupt Source Masking Router

This block collects a set of level-sensitive hardware interrupt lines together with an equal number of software-raised requests. It merges them into one raw request vector. A per-source route select steers each request to one of two outputs. A source whose select bit is 0 goes to the normal interrupt path, and only while its enable bit is set. A source whose select bit is 1 goes to the fast interrupt path, whatever its enable bit holds.

The masked normal-path vector is also brought out on its own port, so that a downstream priority or vectoring unit can choose among the pending sources. This block does no prioritising of its own.

Software reaches the block through a word-addressed bus slave. Through it, software can:
- read the raw request vector and both routed status vectors;
- read and write the route select as a whole word;
- change the enable and software-request registers only through separate set and clear words;
- keep a one-bit protection flag;
- read eight constant identification bytes at the top of the window.

A read or a write to a word that does not exist returns zero and raises an error flag for one cycle. Such an access never stalls the bus.

Top module: `irq_route_top`

## Requirements
- R1: After reset the enable, select, software-request and protection registers are all zero. `irq_out`, `fiq_out`, `irq_vec`, `bus_rdata` and `bus_err` are all low.
- R2: The raw vector is the bitwise OR of `hw_irq` and the software-request register. It reads at word address 2.
- R3: The normal-path status is raw AND enable AND NOT select, and it reads at word 0. The clock edge after the status changes, `irq_vec` takes that status and `irq_out` takes its OR-reduction.
- R4: The fast-path status is raw AND select, and the enable register plays no part in it. It reads at word 1. The clock edge after the status changes, `fiq_out` takes its OR-reduction.
- R5: A write to word 4 ORs the data into enable. A write to word 5 clears each enable bit that is 1 in the data. A read of word 4 returns enable.
- R6: A write to word 6 ORs the data into the software-request register. A write to word 7 clears each bit of that register that is 1 in the data. A read of word 6 returns the register.
- R7: A write to word 3 replaces the whole select register, and a read of word 3 returns it.
- R8: A write to word 8 keeps only data bit 0 as the protection flag. A read of word 8 returns that bit in bit 0, with all other bits zero.
- R9: A write to word 0 changes no register and does not raise `bus_err`.
- R10: A read of word addresses 0x3F8 to 0x3FF (byte offsets 0xFE0 to 0xFFF) returns one constant byte each, in bits 7:0. In address order the bytes are 0x4B, 0x72, 0x19, 0x00, 0xA5, 0x3C, 0x0F, 0xE1.
- R11: The bus accepts an access every cycle. `bus_rdata` and `bus_err` are valid in the cycle after the request. A read of any word other than 0–4, 6, 8 and the identification words returns zero, and a write to any word other than 0 and 3–8 is dropped. In both cases `bus_err` is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | Unmapped access flag, one cycle after the request |
| hw_irq | input | 32 | Level-sensitive hardware interrupt lines |
| irq_vec | output | 32 | Registered masked normal-path vector for a priority unit |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
An enable, select or software-request bit that is stuck or lost shows up in two places. It changes the status words read on the bus in the cycle after the read. It also changes `irq_vec`, `irq_out` or `fiq_out` two clock edges after the write that should have set or cleared it. Routing faults are exposed by sources that are pending but disabled and carry select 1: they must reach the fast path and never the normal one. A decode fault shows as a wrong `bus_err` or a stray non-zero `bus_rdata` one cycle after the access. When a write that should be ignored disturbs a register, the next readback of that register shows it.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int unsigned WA_IRQ_STAT  = 0;
  localparam int unsigned WA_FIQ_STAT  = 1;
  localparam int unsigned WA_RAW       = 2;
  localparam int unsigned WA_SELECT    = 3;
  localparam int unsigned WA_EN_SET    = 4;
  localparam int unsigned WA_EN_CLR    = 5;
  localparam int unsigned WA_SOFT_SET  = 6;
  localparam int unsigned WA_SOFT_CLR  = 7;
  localparam int unsigned WA_PROT      = 8;
  localparam int unsigned WA_ID_BASE   = 'hFE0 >> 2;
  localparam int unsigned ID_WORDS     = 8;

  // constant identification byte for index i of the identification window
  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0:    id_byte = 8'h4B;
      3'd1:    id_byte = 8'h72;
      3'd2:    id_byte = 8'h19;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'hA5;
      3'd5:    id_byte = 8'h3C;
      3'd6:    id_byte = 8'h0F;
      default: id_byte = 8'hE1;
    endcase
  endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int NSRC = 32,
  parameter int AW   = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [NSRC-1:0] wr_data,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] sel_q,
  output logic [NSRC-1:0] soft_q,
  output logic            prot_q
);
  import irq_route_pkg::*;

  logic [NSRC-1:0] en_d, sel_d, soft_d;
  logic            prot_d;
  logic            en_ce, sel_ce, soft_ce, prot_ce;

  always_comb begin
    en_d    = en_q;
    sel_d   = sel_q;
    soft_d  = soft_q;
    prot_d  = prot_q;
    en_ce   = 1'b0;
    sel_ce  = 1'b0;
    soft_ce = 1'b0;
    prot_ce = 1'b0;
    if (wr_en) begin
      if (wr_addr == AW'(WA_SELECT)) begin
        sel_d  = wr_data;
        sel_ce = 1'b1;
      end
      if (wr_addr == AW'(WA_EN_SET)) begin
        en_d  = en_q | wr_data;
        en_ce = 1'b1;
      end
      if (wr_addr == AW'(WA_EN_CLR)) begin
        en_d  = en_q & ~wr_data;
        en_ce = 1'b1;
      end
      if (wr_addr == AW'(WA_SOFT_SET)) begin
        soft_d  = soft_q | wr_data;
        soft_ce = 1'b1;
      end
      if (wr_addr == AW'(WA_SOFT_CLR)) begin
        soft_d  = soft_q & ~wr_data;
        soft_ce = 1'b1;
      end
      if (wr_addr == AW'(WA_PROT)) begin
        prot_d  = wr_data[0];
        prot_ce = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      sel_q  <= '0;
      soft_q <= '0;
      prot_q <= 1'b0;
    end else begin
      if (en_ce)   en_q   <= en_d;
      if (sel_ce)  sel_q  <= sel_d;
      if (soft_ce) soft_q <= soft_d;
      if (prot_ce) prot_q <= prot_d;
    end
  end

endmodule

// File: rtl/irq_route_core.sv
module irq_route_core #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hw_irq,
  input  logic [NSRC-1:0] soft_q,
  input  logic [NSRC-1:0] en_q,
  input  logic [NSRC-1:0] sel_q,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] irq_stat,
  output logic [NSRC-1:0] fiq_stat,
  output logic [NSRC-1:0] irq_vec_q,
  output logic            irq_q,
  output logic            fiq_q
);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign raw[i]      = hw_irq[i] | soft_q[i];
    assign irq_stat[i] = raw[i] & en_q[i] & ~sel_q[i];
    assign fiq_stat[i] = raw[i] & sel_q[i];
  end

  logic [NSRC-1:0] irq_vec_d;
  logic            irq_d, fiq_d;

  always_comb begin
    irq_vec_d = irq_stat;
    irq_d     = |irq_stat;
    fiq_d     = |fiq_stat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_vec_q <= '0;
      irq_q     <= 1'b0;
      fiq_q     <= 1'b0;
    end else begin
      irq_vec_q <= irq_vec_d;
      irq_q     <= irq_d;
      fiq_q     <= fiq_d;
    end
  end

endmodule

// File: rtl/irq_route_rdmux.sv
module irq_route_rdmux #(
  parameter int NSRC = 32,
  parameter int AW   = 10,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] irq_stat,
  input  logic [NSRC-1:0] fiq_stat,
  input  logic [NSRC-1:0] sel_q,
  input  logic [NSRC-1:0] en_q,
  input  logic [NSRC-1:0] soft_q,
  input  logic            prot_q,
  output logic [DW-1:0]   rdata_q,
  output logic            err_q
);
  import irq_route_pkg::*;

  localparam logic [AW-1:0] ID_LO = AW'(WA_ID_BASE);
  localparam logic [AW-1:0] ID_HI = AW'(WA_ID_BASE + ID_WORDS - 1);

  logic [DW-1:0] rdata_d;
  logic          err_d;
  logic          rd_hit, wr_hit;

  always_comb begin
    rdata_d = '0;
    rd_hit  = 1'b1;
    if (addr == AW'(WA_IRQ_STAT))       rdata_d = DW'(irq_stat);
    else if (addr == AW'(WA_FIQ_STAT))  rdata_d = DW'(fiq_stat);
    else if (addr == AW'(WA_RAW))       rdata_d = DW'(raw);
    else if (addr == AW'(WA_SELECT))    rdata_d = DW'(sel_q);
    else if (addr == AW'(WA_EN_SET))    rdata_d = DW'(en_q);
    else if (addr == AW'(WA_SOFT_SET))  rdata_d = DW'(soft_q);
    else if (addr == AW'(WA_PROT))      rdata_d = DW'(prot_q);
    else if (addr >= ID_LO && addr <= ID_HI) rdata_d = DW'(id_byte(addr[2:0]));
    else                                rd_hit  = 1'b0;

    wr_hit = (addr == AW'(WA_IRQ_STAT)) ||
             (addr >= AW'(WA_SELECT) && addr <= AW'(WA_PROT));

    if (!acc) begin
      rdata_d = '0;
      err_d   = 1'b0;
    end else if (wr) begin
      rdata_d = '0;
      err_d   = !wr_hit;
    end else begin
      err_d   = !rd_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top #(
  parameter int NSRC        = 32,
  parameter int AW          = 10,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_err,
  input  logic [NSRC-1:0] hw_irq,
  output logic [NSRC-1:0] irq_vec,
  output logic            irq_out,
  output logic            fiq_out
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  logic [NSRC-1:0] en_q, sel_q, soft_q;
  logic            prot_q;
  logic [NSRC-1:0] raw, irq_stat, fiq_stat;

  irq_route_regs #(.NSRC(NSRC), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (bus_sel && bus_wr),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata[NSRC-1:0]),
    .en_q    (en_q),
    .sel_q   (sel_q),
    .soft_q  (soft_q),
    .prot_q  (prot_q)
  );

  irq_route_core #(.NSRC(NSRC)) u_core (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .hw_irq    (hw_irq),
    .soft_q    (soft_q),
    .en_q      (en_q),
    .sel_q     (sel_q),
    .raw       (raw),
    .irq_stat  (irq_stat),
    .fiq_stat  (fiq_stat),
    .irq_vec_q (irq_vec),
    .irq_q     (irq_out),
    .fiq_q     (fiq_out)
  );

  irq_route_rdmux #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_rdmux (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .acc      (bus_sel),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .raw      (raw),
    .irq_stat (irq_stat),
    .fiq_stat (fiq_stat),
    .sel_q    (sel_q),
    .en_q     (en_q),
    .soft_q   (soft_q),
    .prot_q   (prot_q),
    .rdata_q  (bus_rdata),
    .err_q    (bus_err)
  );

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NSRC = 32,
  parameter int AW   = 10,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic            bus_err,
  input logic            irq_out,
  input logic            fiq_out,
  input logic [NSRC-1:0] irq_vec,
  input logic [NSRC-1:0] irq_stat,
  input logic [NSRC-1:0] fiq_stat,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] soft_q
);
  import irq_route_pkg::*;

  logic wr_en_set, wr_en_clr, wr_sw_set, wr_sw_clr, rd_prot;
  assign wr_en_set = bus_sel && bus_wr && (bus_addr == AW'(WA_EN_SET));
  assign wr_en_clr = bus_sel && bus_wr && (bus_addr == AW'(WA_EN_CLR));
  assign wr_sw_set = bus_sel && bus_wr && (bus_addr == AW'(WA_SOFT_SET));
  assign wr_sw_clr = bus_sel && bus_wr && (bus_addr == AW'(WA_SOFT_CLR));
  assign rd_prot   = bus_sel && !bus_wr && (bus_addr == AW'(WA_PROT));

  p_irq_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec == $past(irq_stat)) && (irq_out == (|$past(irq_stat))));

  p_fiq_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_out == (|$past(fiq_stat)));

  p_en_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_set |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

  p_en_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_clr |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == '0));

  p_sw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sw_set |=> ((soft_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

  p_sw_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sw_clr |=> ((soft_q & $past(bus_wdata[NSRC-1:0])) == '0));

  p_prot_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_prot |=> (bus_rdata[DW-1:1] == '0));

  p_err_needs_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !bus_err);

  p_err_zero_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));

endmodule

bind irq_route_top irq_route_chk #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .irq_out   (irq_out),
  .fiq_out   (fiq_out),
  .irq_vec   (irq_vec),
  .irq_stat  (irq_stat),
  .fiq_stat  (fiq_stat),
  .en_q      (en_q),
  .soft_q    (soft_q)
);

// File: tb/tb_irq_route_top.sv
`timescale 1ns/1ps
module tb_irq_route_top;

  localparam int NSRC = 32;
  localparam int AW   = 10;
  localparam int DW   = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            bus_sel, bus_wr;
  logic [AW-1:0]   bus_addr;
  logic [DW-1:0]   bus_wdata;
  logic [DW-1:0]   bus_rdata;
  logic            bus_err;
  logic [NSRC-1:0] hw_irq;
  logic [NSRC-1:0] irq_vec;
  logic            irq_out, fiq_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  irq_route_top #(.NSRC(NSRC), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .hw_irq(hw_irq), .irq_vec(irq_vec),
    .irq_out(irq_out), .fiq_out(fiq_out)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, output logic err);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    err = bus_err;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic err);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; err = bus_err;
    bus_sel = 1'b0;
  endtask

  task automatic expect_read(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] d; logic e;
    bus_read(a, d, e);
    check(tag, d, exp);
    check({tag, " err"}, DW'(e), '0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic e;
    bus_write(a, d, e);
  endtask

  task automatic t_reset();
    check("R1 irq_out", DW'(irq_out), '0);
    check("R1 fiq_out", DW'(fiq_out), '0);
    check("R1 irq_vec", DW'(irq_vec), '0);
    check("R1 bus_err", DW'(bus_err), '0);
    expect_read("R1 enable", 10'd4, '0);
    expect_read("R1 select", 10'd3, '0);
    expect_read("R1 soft", 10'd6, '0);
    expect_read("R1 prot", 10'd8, '0);
  endtask

  task automatic t_raw_soft();
    @(negedge clk); hw_irq = 32'h0000_00F0;
    wr(10'd6, 32'h0000_0F00);
    expect_read("R6 soft set", 10'd6, 32'h0000_0F00);
    expect_read("R2 raw or", 10'd2, 32'h0000_0FF0);
    wr(10'd7, 32'h0000_0300);
    expect_read("R6 soft clear", 10'd6, 32'h0000_0C00);
    expect_read("R2 raw after clear", 10'd2, 32'h0000_0CF0);
  endtask

  task automatic t_enable();
    wr(10'd4, 32'h0000_00FF);
    wr(10'd4, 32'h0000_1000);
    expect_read("R5 enable set accumulates", 10'd4, 32'h0000_10FF);
    wr(10'd5, 32'h0000_000F);
    expect_read("R5 enable clear", 10'd4, 32'h0000_10F0);
  endtask

  task automatic t_irq_path();
    expect_read("R3 irq status", 10'd0, 32'h0000_00F0);
    check("R3 irq_vec", irq_vec, 32'h0000_00F0);
    check("R3 irq_out", DW'(irq_out), 32'd1);
    check("R4 fiq_out idle", DW'(fiq_out), '0);
  endtask

  task automatic t_fiq_path();
    wr(10'd3, 32'h0000_0C30);
    @(negedge clk);
    expect_read("R7 select readback", 10'd3, 32'h0000_0C30);
    expect_read("R4 fiq status ignores enable", 10'd1, 32'h0000_0C30);
    expect_read("R3 select removes from irq", 10'd0, 32'h0000_00C0);
    check("R4 fiq_out", DW'(fiq_out), 32'd1);
    check("R3 irq_vec masked", irq_vec, 32'h0000_00C0);
    @(negedge clk); hw_irq = '0;
    @(negedge clk);
    check("R3 irq_out one cycle after input", DW'(irq_out), '0);
    check("R4 fiq_out held by soft", DW'(fiq_out), 32'd1);
    wr(10'd3, 32'h0000_0000);
    check("R4 fiq_out not yet dropped", DW'(fiq_out), 32'd1);
    @(negedge clk);
    check("R4 fiq_out dropped", DW'(fiq_out), '0);
    check("R3 disabled soft stays off", DW'(irq_out), '0);
  endtask

  task automatic t_prot();
    wr(10'd8, 32'hFFFF_FFFF);
    expect_read("R8 prot bit0", 10'd8, 32'h0000_0001);
    wr(10'd8, 32'h0000_0002);
    expect_read("R8 prot only bit0", 10'd8, '0);
  endtask

  task automatic t_ignored();
    logic e;
    bus_write(10'd0, 32'hFFFF_FFFF, e);
    check("R9 no error", DW'(e), '0);
    expect_read("R9 enable unchanged", 10'd4, 32'h0000_10F0);
    expect_read("R9 select unchanged", 10'd3, '0);
    expect_read("R9 soft unchanged", 10'd6, 32'h0000_0C00);
  endtask

  task automatic t_id();
    logic [7:0] exp_id [8];
    exp_id = '{8'h4B, 8'h72, 8'h19, 8'h00, 8'hA5, 8'h3C, 8'h0F, 8'hE1};
    for (int i = 0; i < 8; i++)
      expect_read($sformatf("R10 id word %0d", i), AW'(10'h3F8 + i), DW'(exp_id[i]));
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] d; logic e;
    bus_read(10'd5, d, e);
    check("R11 read clr word data", d, '0);
    check("R11 read clr word err", DW'(e), 32'd1);
    @(negedge clk);
    check("R11 err single cycle", DW'(bus_err), '0);
    bus_read(10'h100, d, e);
    check("R11 read hole data", d, '0);
    check("R11 read hole err", DW'(e), 32'd1);
    bus_write(10'h050, 32'hFFFF_FFFF, e);
    check("R11 write hole err", DW'(e), 32'd1);
    bus_write(10'd2, 32'hFFFF_FFFF, e);
    check("R11 write raw err", DW'(e), 32'd1);
    expect_read("R11 enable untouched", 10'd4, 32'h0000_10F0);
    expect_read("R11 soft untouched", 10'd6, 32'h0000_0C00);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; hw_irq = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_raw_soft();
    t_enable();
    t_irq_path();
    t_fiq_path();
    t_prot();
    t_ignored();
    t_id();
    t_unmapped();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule